// File: doc/BRIEF.md
# Genlock Vertical Frame Alignment Checker

When the display timing is slaved to an outside video source, this block keeps the local vertical counter in step with the incoming fields. The local timing generator sends a one-cycle strobe at the start of each of its fields, along with that field's parity. The external reference sends its own field-start strobe and parity. At every local field start whose parity is selected for checking, the block judges whether the two sources agree. If they do not, it resets the local vertical counter.

Two policies are available. In preload mode, every misaligned field triggers the counter reset at once. Otherwise the block tolerates drift. It counts consecutive misaligned fields, shows the running count on a readable output, and only issues the reset when the seventh misaligned field in a row arrives. In master mode the local timing runs free and the block stays idle.

Top module: `genlock_frame_align`

## Requirements
- R1: While `rst` is high at a clock edge, `vc_reset` is 0 and `miss_run` is 0 after that edge.
- R2: While `slave_en` is 0 (master mode), `vc_reset` stays 0 and `miss_run` reads 0 from the cycle after the edge where `slave_en` was sampled low.
- R3: A field is checked only in a cycle where `loc_field_go` is 1. It is aligned when `ref_field_go` is 1 in that same cycle and `ref_odd` equals `loc_odd` (parity 1 means odd field).
- R4: With `check_sel` = 0 only local odd fields (`loc_odd` = 1) are checked. With `check_sel` = 1 only local even fields (`loc_odd` = 0) are checked.
- R5: With `check_sel` = 2 or 3, fields of both parities are checked.
- R6: With `instant_mode` = 1, every misaligned checked field raises `vc_reset` in the cycle after its local field start.
- R7: With `instant_mode` = 0, each misaligned checked field adds one to `miss_run` in the next cycle. The seventh consecutive one raises `vc_reset` instead and returns `miss_run` to 0.
- R8: An aligned checked field returns `miss_run` to 0 in the next cycle and raises no reset.
- R9: While `instant_mode` is 1, `miss_run` reads 0 from the cycle after the edge where it was sampled high.
- R10: A local field start whose parity is not selected leaves `miss_run` unchanged and raises no reset.
- R11: `vc_reset` is high for exactly one cycle per reset request. Because field-start strobes are never high in two adjacent cycles, it is never high two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_en | input | 1 | 1 = genlock (slaved) operation, 0 = master mode |
| instant_mode | input | 1 | 1 = reset on every misaligned field, 0 = reset after 7 in a row |
| check_sel | input | 2 | Field select: 0 odd, 1 even, 2 or 3 both |
| loc_field_go | input | 1 | One-cycle strobe at the start of a local field |
| loc_odd | input | 1 | Parity of the local field starting now (1 = odd) |
| ref_field_go | input | 1 | One-cycle strobe at the start of an external field |
| ref_odd | input | 1 | Parity of the external field starting now (1 = odd) |
| vc_reset | output | 1 | One-cycle request to reset the local vertical counter |
| miss_run | output | 3 | Number of consecutive misaligned checked fields |

## Verification
The assertions assume that the local field-start strobe is never high in two adjacent cycles, since a real field lasts many lines. The pulse-width property depends on that. The stimulus always follows each field event with at least one idle cycle.

The random phase draws parity, coincidence and the control settings with `$urandom`, and changes the controls only between events. Misses are weighted heavily so that runs of seven actually occur. Directed runs then cover the exact seventh-miss boundary, a hit that interrupts a run, ignored parities, and master mode.

// File: rtl/gfa_pkg.sv
package gfa_pkg;
  typedef enum logic [1:0] {
    SEL_ODD   = 2'd0,
    SEL_EVEN  = 2'd1,
    SEL_BOTH  = 2'd2,
    SEL_BOTH2 = 2'd3
  } field_pick_e;
endpackage

// File: rtl/gfa_field_judge.sv
// Decides whether the current local field start is to be checked and, if so,
// whether the external reference agrees with it.
module gfa_field_judge
  import gfa_pkg::*;
(
  input  logic [1:0] check_sel,
  input  logic       loc_field_go,
  input  logic       loc_odd,
  input  logic       ref_field_go,
  input  logic       ref_odd,
  output logic       judge_now,
  output logic       judge_hit
);
  logic parity_wanted;

  always_comb begin
    unique case (field_pick_e'(check_sel))
      SEL_ODD:  parity_wanted = loc_odd;
      SEL_EVEN: parity_wanted = ~loc_odd;
      default:  parity_wanted = 1'b1;
    endcase
  end

  assign judge_now = loc_field_go & parity_wanted;
  assign judge_hit = ref_field_go & (ref_odd == loc_odd);
endmodule

// File: rtl/gfa_run_counter.sv
// Tracks consecutive misaligned fields and issues the counter-reset pulse.
module gfa_run_counter #(
  parameter int MISS_LIMIT = 7,
  localparam int CNT_W = $clog2(MISS_LIMIT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slave_en,
  input  logic             instant_mode,
  input  logic             judge_now,
  input  logic             judge_hit,
  input  logic             strobe,
  output logic [CNT_W-1:0] run_cnt,
  output logic             fire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MISS_LIMIT - 1);

  always_ff @(posedge clk) begin
    if (rst || !slave_en) begin
      run_cnt <= '0;
      fire    <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (judge_now) begin
        if (judge_hit) begin
          run_cnt <= '0;
        end else if (instant_mode || run_cnt == LAST) begin
          fire    <= 1'b1;
          run_cnt <= '0;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end else if (instant_mode) begin
        run_cnt <= '0;
      end
    end
  end

  assert_quiet_master_R2: assert property (@(posedge clk) disable iff (rst)
    !slave_en |=> (!fire && run_cnt == '0));
  assert_instant_miss_R6: assert property (@(posedge clk) disable iff (rst)
    (slave_en && instant_mode && judge_now && !judge_hit) |=> fire);
  assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
    (slave_en && !instant_mode && judge_now && !judge_hit && run_cnt != LAST)
    |=> (run_cnt == $past(run_cnt) + 1'b1 && !fire));
  assert_limit_fire_R7: assert property (@(posedge clk) disable iff (rst)
    (slave_en && !instant_mode && judge_now && !judge_hit && run_cnt == LAST)
    |=> (fire && run_cnt == '0));
  assert_hit_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (slave_en && judge_now && judge_hit) |=> (run_cnt == '0 && !fire));
  assert_instant_zero_R9: assert property (@(posedge clk) disable iff (rst)
    instant_mode |=> run_cnt == '0);
  assert_hold_unchecked_R10: assert property (@(posedge clk) disable iff (rst)
    (slave_en && !instant_mode && !judge_now) |=> ($stable(run_cnt) && !fire));
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (fire && !strobe) |=> !fire);
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= LAST);
endmodule

// File: rtl/genlock_frame_align.sv
module genlock_frame_align #(
  parameter int MISS_LIMIT = 7,
  localparam int CNT_W = $clog2(MISS_LIMIT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slave_en,
  input  logic             instant_mode,
  input  logic [1:0]       check_sel,
  input  logic             loc_field_go,
  input  logic             loc_odd,
  input  logic             ref_field_go,
  input  logic             ref_odd,
  output logic             vc_reset,
  output logic [CNT_W-1:0] miss_run
);
  logic judge_now;
  logic judge_hit;

  gfa_field_judge u_judge (
    .check_sel    (check_sel),
    .loc_field_go (loc_field_go),
    .loc_odd      (loc_odd),
    .ref_field_go (ref_field_go),
    .ref_odd      (ref_odd),
    .judge_now    (judge_now),
    .judge_hit    (judge_hit)
  );

  gfa_run_counter #(.MISS_LIMIT(MISS_LIMIT)) u_count (
    .clk          (clk),
    .rst          (rst),
    .slave_en     (slave_en),
    .instant_mode (instant_mode),
    .judge_now    (judge_now),
    .judge_hit    (judge_hit),
    .strobe       (loc_field_go),
    .run_cnt      (miss_run),
    .fire         (vc_reset)
  );

  assert_only_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !loc_field_go |=> !vc_reset);
  assert_odd_only_R4: assert property (@(posedge clk) disable iff (rst)
    (check_sel == 2'd0 && loc_field_go && !loc_odd) |=> !vc_reset);
  assert_even_only_R4: assert property (@(posedge clk) disable iff (rst)
    (check_sel == 2'd1 && loc_field_go && loc_odd) |=> !vc_reset);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!vc_reset && miss_run == '0));
endmodule

// File: tb/genlock_frame_align_test.sv
`timescale 1ns/1ps
module genlock_frame_align_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slave_en = 1'b0;
  logic instant_mode = 1'b0;
  logic [1:0] check_sel = 2'd2;
  logic loc_field_go = 1'b0, loc_odd = 1'b0, ref_field_go = 1'b0, ref_odd = 1'b0;
  logic vc_reset;
  logic [2:0] miss_run;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int m_cnt = 0;
  bit m_fire = 1'b0;

  always #2.5 clk = ~clk;

  genlock_frame_align uut (
    .clk(clk), .rst(rst), .slave_en(slave_en), .instant_mode(instant_mode),
    .check_sel(check_sel), .loc_field_go(loc_field_go), .loc_odd(loc_odd),
    .ref_field_go(ref_field_go), .ref_odd(ref_odd),
    .vc_reset(vc_reset), .miss_run(miss_run)
  );

  function automatic bit selected(input logic [1:0] sel, input logic odd);
    if (sel == 2'd0) return odd;
    if (sel == 2'd1) return !odd;
    return 1'b1;
  endfunction

  // Expected next state computed from the requirements.
  task automatic model_edge();
    bit chk;
    bit hit;
    if (rst || !slave_en) begin
      m_cnt = 0; m_fire = 0;
    end else begin
      m_fire = 0;
      chk = loc_field_go && selected(check_sel, loc_odd);
      hit = ref_field_go && (ref_odd == loc_odd);
      if (chk) begin
        if (hit) m_cnt = 0;
        else if (instant_mode || m_cnt == 6) begin m_fire = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end else if (instant_mode) m_cnt = 0;
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, model at posedge, sample just after.
  task automatic tick(input logic lfs, input logic lodd, input logic efs,
                      input logic eodd, input string tag);
    @(negedge clk);
    loc_field_go = lfs; loc_odd = lodd; ref_field_go = efs; ref_odd = eodd;
    @(posedge clk);
    model_edge();
    #1;
    check({tag, " vc_reset"}, int'(vc_reset), int'(m_fire));
    check({tag, " miss_run"}, int'(miss_run), m_cnt);
  endtask

  task automatic field(input logic lodd, input logic efs, input logic eodd,
                       input string tag);
    tick(1'b1, lodd, efs, eodd, tag);
    tick(1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic set_ctl(input logic s, input logic p, input logic [1:0] sel);
    @(negedge clk);
    slave_en = s; instant_mode = p; check_sel = sel;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int r;
    int pass;
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    tick(1'b1, 1'b1, 1'b0, 1'b0, "R1");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "R1");
    check("R1 vc_reset", int'(vc_reset), 0);
    check("R1 miss_run", int'(miss_run), 0);
    @(negedge clk); rst = 1'b0;

    // R2: master mode, misses have no effect
    set_ctl(1'b0, 1'b0, 2'd2);
    for (int i = 0; i < 10; i++) field(i[0], 1'b0, 1'b0, "R2");
    check("R2 miss_run", int'(miss_run), 0);

    // R7: six misses count up, seventh fires
    set_ctl(1'b1, 1'b0, 2'd2);
    for (int i = 0; i < 6; i++) field(i[0], 1'b0, 1'b0, "R7");
    check("R7 count six", int'(miss_run), 6);
    tick(1'b1, 1'b1, 1'b0, 1'b1, "R7");
    check("R7 seventh fires", int'(vc_reset), 1);
    check("R7 count wraps", int'(miss_run), 0);
    tick(1'b0, 1'b0, 1'b0, 1'b0, "R11");
    check("R11 pulse ends", int'(vc_reset), 0);

    // R8: hit interrupts a run; parity mismatch counts as miss (R3)
    for (int i = 0; i < 4; i++) field(1'b1, 1'b1, 1'b0, "R3");
    check("R3 parity mismatch counted", int'(miss_run), 4);
    field(1'b0, 1'b1, 1'b0, "R8");
    check("R8 hit clears", int'(miss_run), 0);
    tick(1'b0, 1'b0, 1'b1, 1'b1, "R3");
    check("R3 lone ref strobe", int'(miss_run), 0);

    // R4: odd only; even misses ignored (R10)
    set_ctl(1'b1, 1'b0, 2'd0);
    field(1'b1, 1'b0, 1'b0, "R4");
    check("R4 odd checked", int'(miss_run), 1);
    field(1'b0, 1'b0, 1'b0, "R10");
    check("R10 even ignored", int'(miss_run), 1);
    set_ctl(1'b1, 1'b0, 2'd1);
    field(1'b1, 1'b0, 1'b0, "R10");
    check("R4 odd ignored in even sel", int'(miss_run), 1);
    field(1'b0, 1'b0, 1'b0, "R4");
    check("R4 even checked", int'(miss_run), 2);

    // R5: select 3 behaves as both
    set_ctl(1'b1, 1'b0, 2'd3);
    field(1'b1, 1'b0, 1'b0, "R5");
    field(1'b0, 1'b0, 1'b0, "R5");
    check("R5 both parities", int'(miss_run), 4);

    // R6/R9: instant mode
    set_ctl(1'b1, 1'b1, 2'd2);
    tick(1'b0, 1'b0, 1'b0, 1'b0, "R9");
    check("R9 count zero", int'(miss_run), 0);
    tick(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    check("R6 immediate reset", int'(vc_reset), 1);
    tick(1'b0, 1'b0, 1'b0, 1'b0, "R11");
    check("R11 single cycle", int'(vc_reset), 0);

    // Random phase against the model
    for (int i = 0; i < 3000; i++) begin
      r = int'($urandom_range(0, 99));
      if (r < 4) set_ctl($urandom_range(0, 9) != 0, $urandom_range(0, 3) == 0,
                         2'($urandom_range(0, 3)));
      pass = int'($urandom_range(0, 99));
      if (pass < 70)
        field(1'($urandom), pass < 15, 1'($urandom), "R7 random");
      else
        tick(1'b0, 1'b0, 1'($urandom_range(0, 4) == 0), 1'($urandom), "R10 random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule